// File: doc/BRIEF.md
# SD Command Issue and Response Engine

This block drives the command line of an SD/MMC card interface. A host presents a 6-bit command index, a 32-bit argument and a response setting through a valid/ready handshake. The engine builds a 48-bit command frame with its CRC7 and shifts it out one bit per card-clock strobe. If a response is expected, it releases the line, waits for the card's start bit and captures a short (48-bit) or long (136-bit) reply into four 32-bit response words.

Back-pressure rules: `cmd_ready` is high only while the engine is idle. A command is taken on a clock edge where `cmd_valid` and `cmd_ready` are both high. While `cmd_ready` is low, `cmd_valid` and the command fields are ignored and the host may hold or change them freely. `busy` marks the span from acceptance to completion. The two error flags describe the most recent command and remain valid until the next one is accepted. Card-clock generation and the data lines are outside this block. `clk_stb` is a one-cycle pulse from the clock divider that marks each card-clock edge.

Top module: `sdc_cmd_engine`

## Requirements
- R1: `cmd_ready` is 1 exactly when `busy` is 0. A command is accepted on an edge with `cmd_valid` and `cmd_ready` both high. `busy` is high from the next cycle. Inputs presented while `cmd_ready` is 0 do not alter the frame in flight.
- R2: After acceptance, each `clk_stb` drives the next frame bit on `cmd_out`, MSB first, with `cmd_oe` high. The frame is, from first bit to last: start bit 0, direction bit 1, index[5:0], argument[31:0], CRC7[6:0], end bit 1 (48 bits).
- R3: The CRC7 uses the polynomial x^7+x^3+1 with a zero initial value, taken over the first 40 frame bits. Index 0 with argument 0 gives 0x4A. Index 17 with argument 0 gives 0x2A.
- R4: The strobe after the end bit clears `cmd_oe`. If the response enable is 0, `busy` also clears at that strobe and both error flags stay 0.
- R5: With the response enable set, the first strobe that samples `cmd_in` low is the response start bit. If 64 consecutive strobes sample it high, `no_rsp_err` is set and `busy` clears at the 64th strobe.
- R6: Format 0 (and 3) is a 48-bit response. On completion `rsp_w3` holds frame bits 39:8 and `rsp_w2..rsp_w0` are 0. `rsp_err` is set if the direction bit (bit 46) is not 0, the end bit is not 1, or bits 7:1 differ from the CRC7 of bits 47:8.
- R7: Format 1 is a 48-bit response with the CRC not checked. A wrong CRC leaves `rsp_err` 0, but the direction and end bits are still checked.
- R8: Format 2 is a 136-bit response. `rsp_w3`, `rsp_w2` and `rsp_w1` hold frame bits 127:96, 95:64 and 63:32. `rsp_w0` holds bits 31:1 shifted right by one, with bit 31 equal to 0. `rsp_err` is set if bits 135:128 are not 0,0,111111 or the end bit is 0.
- R9: `busy` stays high for the whole response, including any idle strobes before the start bit, and clears on the strobe of the last response bit. Both error flags clear on acceptance.
- R10: `cmd_out` and `cmd_oe` change only on cycles where `clk_stb` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command request valid |
| cmd_ready | output | 1 | Engine idle, can accept a command |
| cmd_idx | input | 6 | Command index |
| cmd_arg | input | 32 | Command argument |
| rsp_en | input | 1 | Expect a response |
| rsp_fmt | input | 2 | Response format: 0 short, 1 short without CRC check, 2 long, 3 as 0 |
| clk_stb | input | 1 | Card-clock strobe, one cycle per card clock |
| cmd_out | output | 1 | Command line output value |
| cmd_oe | output | 1 | Command line output enable |
| cmd_in | input | 1 | Command line input value |
| busy | output | 1 | Operation in progress |
| no_rsp_err | output | 1 | No start bit within the timeout |
| rsp_err | output | 1 | Response framing or CRC error |
| rsp_w3 | output | 32 | Response word 3 (short response payload / long bits 127:96) |
| rsp_w2 | output | 32 | Response word 2 |
| rsp_w1 | output | 32 | Response word 1 |
| rsp_w0 | output | 32 | Response word 0 (long bits 31:1, right-aligned) |

## Verification
The bench captures the full serial frame and compares it against a frame and CRC7 it builds on its own, including the two known CRC values. A shifted or wrongly seeded CRC would show up at once. The timeout is checked at both sides of its edge: still busy after 63 idle strobes, and flagged at the 64th. An off-by-one counter would trip one of these two checks. Each format is given a reply with a bad CRC, a bad end bit or a late start bit. An engine that checked the CRC in format 1, skipped it in format 0, or misaligned the low long word by one bit would report a wrong flag or word. A second command held on the handshake during a transfer must not corrupt the frame in flight.

// File: rtl/sdc_pkg.sv
package sdc_pkg;

  typedef enum logic [1:0] {
    FMT_SHORT = 2'd0,
    FMT_NOCRC = 2'd1,
    FMT_LONG  = 2'd2,
    FMT_ALT   = 2'd3
  } rsp_fmt_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SEND,
    ST_WAIT,
    ST_RECV
  } eng_st_e;

  // Serial CRC7, x^7 + x^3 + 1, zero seed, MSB first over 40 bits
  function automatic logic [6:0] crc7_40(input logic [39:0] d);
    logic [6:0] c;
    logic       fb;
    c = '0;
    for (int i = 39; i >= 0; i--) begin
      fb = d[i] ^ c[6];
      c  = {c[5:0], 1'b0};
      if (fb) c = c ^ 7'h09;
    end
    return c;
  endfunction

endpackage

// File: rtl/sdc_tx_ser.sv
module sdc_tx_ser #(
  parameter int FRAME_W = 48
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [FRAME_W-1:0] frame_in,
  input  logic               shift,
  output logic               bit_out
);
  logic [FRAME_W-1:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sh <= '0;
    else if (load)  sh <= frame_in;
    else if (shift) sh <= {sh[FRAME_W-2:0], 1'b0};
  end

  assign bit_out = sh[FRAME_W-1];
endmodule

// File: rtl/sdc_rx_des.sv
module sdc_rx_des #(
  parameter int FRAME_W = 136
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               shift,
  input  logic               din,
  output logic [FRAME_W-1:0] sh_next
);
  logic [FRAME_W-1:0] sh;

  assign sh_next = {sh[FRAME_W-2:0], din};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sh <= '0;
    else if (clr)   sh <= '0;
    else if (shift) sh <= sh_next;
  end
endmodule

// File: rtl/sdc_rsp_chk.sv
module sdc_rsp_chk
  import sdc_pkg::*;
#(
  parameter int LONG_W  = 136,
  parameter int SHORT_W = 48
) (
  input  logic [LONG_W-1:0] frame,
  input  rsp_fmt_e          fmt,
  output logic              err,
  output logic [31:0]       w3,
  output logic [31:0]       w2,
  output logic [31:0]       w1,
  output logic [31:0]       w0
);
  logic [SHORT_W-1:0] sf;
  logic               crc_bad;

  assign sf      = frame[SHORT_W-1:0];
  assign crc_bad = (crc7_40(sf[47:8]) != sf[7:1]);

  always_comb begin
    if (fmt == FMT_LONG) begin
      err = (frame[135:128] != 8'b0011_1111) | ~frame[0];
      w3  = frame[127:96];
      w2  = frame[95:64];
      w1  = frame[63:32];
      w0  = {1'b0, frame[31:1]};
    end else begin
      err = sf[47] | sf[46] | ~sf[0] | ((fmt != FMT_NOCRC) & crc_bad);
      w3  = sf[39:8];
      w2  = '0;
      w1  = '0;
      w0  = '0;
    end
  end
endmodule

// File: rtl/sdc_cmd_engine.sv
module sdc_cmd_engine
  import sdc_pkg::*;
#(
  parameter int TIMEOUT = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_valid,
  output logic        cmd_ready,
  input  logic [5:0]  cmd_idx,
  input  logic [31:0] cmd_arg,
  input  logic        rsp_en,
  input  logic [1:0]  rsp_fmt,
  input  logic        clk_stb,
  output logic        cmd_out,
  output logic        cmd_oe,
  input  logic        cmd_in,
  output logic        busy,
  output logic        no_rsp_err,
  output logic        rsp_err,
  output logic [31:0] rsp_w3,
  output logic [31:0] rsp_w2,
  output logic [31:0] rsp_w1,
  output logic [31:0] rsp_w0
);
  localparam int CMD_W  = 48;
  localparam int LONG_W = 136;
  localparam int CNT_W  = $clog2(LONG_W + 1);
  localparam int TMO_W  = (TIMEOUT > 1) ? $clog2(TIMEOUT) : 1;

  eng_st_e            state;
  logic [CNT_W-1:0]   cnt;
  logic [TMO_W-1:0]   tmr;
  logic               en_q;
  rsp_fmt_e           fmt_q;
  logic               accept;
  logic [CMD_W-1:0]   tx_frame;
  logic               tx_bit;
  logic               tx_shift;
  logic               rx_shift;
  logic [LONG_W-1:0]  rx_next;
  logic               chk_err;
  logic [31:0]        c_w3, c_w2, c_w1, c_w0;
  logic [CNT_W-1:0]   last_idx;

  assign cmd_ready = (state == ST_IDLE);
  assign busy      = (state != ST_IDLE);
  assign accept    = cmd_valid && cmd_ready;

  assign tx_frame = {2'b01, cmd_idx, cmd_arg, crc7_40({2'b01, cmd_idx, cmd_arg}), 1'b1};
  assign tx_shift = clk_stb && (state == ST_SEND) && (cnt != CNT_W'(CMD_W));
  assign rx_shift = clk_stb && (((state == ST_WAIT) && !cmd_in) || (state == ST_RECV));
  assign last_idx = (fmt_q == FMT_LONG) ? CNT_W'(LONG_W - 1) : CNT_W'(CMD_W - 1);

  sdc_tx_ser #(.FRAME_W(CMD_W)) u_tx (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (accept),
    .frame_in (tx_frame),
    .shift    (tx_shift),
    .bit_out  (tx_bit)
  );

  sdc_rx_des #(.FRAME_W(LONG_W)) u_rx (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (accept),
    .shift   (rx_shift),
    .din     (cmd_in),
    .sh_next (rx_next)
  );

  sdc_rsp_chk #(.LONG_W(LONG_W), .SHORT_W(CMD_W)) u_chk_rsp (
    .frame (rx_next),
    .fmt   (fmt_q),
    .err   (chk_err),
    .w3    (c_w3),
    .w2    (c_w2),
    .w1    (c_w1),
    .w0    (c_w0)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      cnt        <= '0;
      tmr        <= '0;
      en_q       <= 1'b0;
      fmt_q      <= FMT_SHORT;
      cmd_out    <= 1'b1;
      cmd_oe     <= 1'b0;
      no_rsp_err <= 1'b0;
      rsp_err    <= 1'b0;
      rsp_w3     <= '0;
      rsp_w2     <= '0;
      rsp_w1     <= '0;
      rsp_w0     <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (accept) begin
            state      <= ST_SEND;
            cnt        <= '0;
            en_q       <= rsp_en;
            fmt_q      <= rsp_fmt_e'(rsp_fmt);
            no_rsp_err <= 1'b0;
            rsp_err    <= 1'b0;
          end
        end
        ST_SEND: begin
          if (clk_stb) begin
            if (cnt == CNT_W'(CMD_W)) begin
              cmd_oe  <= 1'b0;
              cmd_out <= 1'b1;
              tmr     <= '0;
              state   <= en_q ? ST_WAIT : ST_IDLE;
            end else begin
              cmd_out <= tx_bit;
              cmd_oe  <= 1'b1;
              cnt     <= cnt + 1'b1;
            end
          end
        end
        ST_WAIT: begin
          if (clk_stb) begin
            if (!cmd_in) begin
              state <= ST_RECV;
              cnt   <= CNT_W'(1);
            end else if (tmr == TMO_W'(TIMEOUT - 1)) begin
              no_rsp_err <= 1'b1;
              state      <= ST_IDLE;
            end else begin
              tmr <= tmr + 1'b1;
            end
          end
        end
        ST_RECV: begin
          if (clk_stb) begin
            if (cnt == last_idx) begin
              state   <= ST_IDLE;
              rsp_err <= chk_err;
              rsp_w3  <= c_w3;
              rsp_w2  <= c_w2;
              rsp_w1  <= c_w1;
              rsp_w0  <= c_w0;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sdc_cmd_chk.sv
module sdc_cmd_chk (
  input logic clk,
  input logic rst_n,
  input logic cmd_valid,
  input logic cmd_ready,
  input logic clk_stb,
  input logic cmd_out,
  input logic cmd_oe,
  input logic busy,
  input logic no_rsp_err,
  input logic rsp_err
);
  // R1: an accepted command makes the engine busy on the next cycle
  a_r1_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready |=> busy);

  // R2: the line is only driven during an operation
  a_r2_oe_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_oe |-> busy);

  // R2: the first driven bit is the start bit 0
  a_r2_start_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmd_oe) |-> !cmd_out);

  // R4: release of the line happens on a strobe
  a_r4_release_on_stb: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cmd_oe) |-> $past(clk_stb));

  // R10: line outputs hold between strobes
  a_r10_hold_no_stb: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_stb |=> $stable(cmd_out) && $stable(cmd_oe));

  // R5: a timeout ends the operation in the same cycle
  a_r5_timeout_done: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(no_rsp_err) |-> $fell(busy));

  // R9: the two error flags never coexist
  a_r9_flags_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(no_rsp_err && rsp_err));
endmodule

bind sdc_cmd_engine sdc_cmd_chk u_sva (
  .clk        (clk),
  .rst_n      (rst_n),
  .cmd_valid  (cmd_valid),
  .cmd_ready  (cmd_ready),
  .clk_stb    (clk_stb),
  .cmd_out    (cmd_out),
  .cmd_oe     (cmd_oe),
  .busy       (busy),
  .no_rsp_err (no_rsp_err),
  .rsp_err    (rsp_err)
);

// File: tb/sim_sdc_cmd_engine.sv
module sim_sdc_cmd_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [5:0]  cmd_idx = '0;
  logic [31:0] cmd_arg = '0;
  logic        rsp_en = 1'b0;
  logic [1:0]  rsp_fmt = '0;
  logic        clk_stb = 1'b0;
  logic        cmd_out, cmd_oe;
  logic        cmd_in = 1'b1;
  logic        busy, no_rsp_err, rsp_err;
  logic [31:0] rsp_w3, rsp_w2, rsp_w1, rsp_w0;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  sdc_cmd_engine u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_idx(cmd_idx), .cmd_arg(cmd_arg), .rsp_en(rsp_en), .rsp_fmt(rsp_fmt),
    .clk_stb(clk_stb), .cmd_out(cmd_out), .cmd_oe(cmd_oe), .cmd_in(cmd_in),
    .busy(busy), .no_rsp_err(no_rsp_err), .rsp_err(rsp_err),
    .rsp_w3(rsp_w3), .rsp_w2(rsp_w2), .rsp_w1(rsp_w1), .rsp_w0(rsp_w0)
  );

  task automatic check(input bit ok, input string req, input logic [135:0] act,
                       input logic [135:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [6:0] ref_crc(input logic [39:0] d);
    logic [6:0] r = '0;
    for (int k = 39; k >= 0; k--) begin
      logic top;
      top = r[6] ^ d[k];
      r = {r[5:0], 1'b0} ^ (top ? 7'b0001001 : 7'b0);
    end
    return r;
  endfunction

  function automatic logic [47:0] cmd_frame(input logic [5:0] i, input logic [31:0] a);
    return {2'b01, i, a, ref_crc({2'b01, i, a}), 1'b1};
  endfunction

  function automatic logic [47:0] short_rsp(input logic [5:0] i, input logic [31:0] s);
    return {2'b00, i, s, ref_crc({2'b00, i, s}), 1'b1};
  endfunction

  // one card-clock strobe, cmd_in presented with it; returns after the edge
  task automatic tick(input logic din);
    @(negedge clk);
    cmd_in  = din;
    clk_stb = 1'b1;
    @(negedge clk);
    clk_stb = 1'b0;
    cmd_in  = 1'b1;
    @(negedge clk);
  endtask

  task automatic issue(input logic [5:0] i, input logic [31:0] a, input logic en,
                       input logic [1:0] f);
    @(negedge clk);
    cmd_idx = i; cmd_arg = a; rsp_en = en; rsp_fmt = f; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    check(busy && !cmd_ready, "R1 busy after accept", {busy, cmd_ready}, 2'b10);
    check(!no_rsp_err && !rsp_err, "R9 flags cleared on accept",
          {no_rsp_err, rsp_err}, 0);
  endtask

  // shift out 48 bits and the release strobe; returns captured frame
  task automatic capture(output logic [47:0] got, output bit oe_ok);
    got = '0; oe_ok = 1;
    for (int k = 0; k < 48; k++) begin
      tick(1'b1);
      got = {got[46:0], cmd_out};
      if (!cmd_oe) oe_ok = 0;
    end
    tick(1'b1);
  endtask

  task automatic send_bits(input logic [135:0] v, input int len);
    for (int k = len - 1; k >= 0; k--) begin
      if (k == 0) check(busy, "R9 busy until last bit", busy, 1);
      tick(v[k]);
    end
  endtask

  task automatic t_reset;
    check(!busy && cmd_ready && !cmd_oe, "R1 reset idle", {busy, cmd_ready, cmd_oe}, 3'b010);
    check(!no_rsp_err && !rsp_err, "R9 reset flags", {no_rsp_err, rsp_err}, 0);
  endtask

  task automatic t_no_rsp_cmd0;
    logic [47:0] got; bit ok;
    issue(6'd0, 32'h0, 1'b0, 2'd0);
    capture(got, ok);
    check(got == cmd_frame(6'd0, 32'h0), "R2 frame cmd0", got, cmd_frame(6'd0, 32'h0));
    check(got[7:1] == 7'h4A, "R3 crc cmd0", got[7:1], 7'h4A);
    check(ok, "R2 oe during frame", ok, 1);
    check(!cmd_oe && !busy && !no_rsp_err && !rsp_err, "R4 release no response",
          {cmd_oe, busy, no_rsp_err, rsp_err}, 0);
  endtask

  task automatic t_short_ok;
    logic [47:0] got; bit ok;
    issue(6'd17, 32'h0, 1'b1, 2'd0);
    capture(got, ok);
    check(got[7:1] == 7'h2A, "R3 crc cmd17", got[7:1], 7'h2A);
    check(!cmd_oe && busy, "R4 released, waiting", {cmd_oe, busy}, 2'b01);
    send_bits({88'b0, short_rsp(6'd17, 32'hCAFE_0900)}, 48);
    check(!busy && !rsp_err && !no_rsp_err, "R6 short ok flags",
          {busy, rsp_err, no_rsp_err}, 0);
    check(rsp_w3 == 32'hCAFE_0900, "R6 short word3", rsp_w3, 32'hCAFE_0900);
    check({rsp_w2, rsp_w1, rsp_w0} == 0, "R6 short others zero",
          {rsp_w2, rsp_w1, rsp_w0}, 0);
  endtask

  task automatic t_short_badcrc(input logic [1:0] f, input bit exp_err, input string req);
    logic [47:0] got; bit ok; logic [47:0] r;
    issue(6'd13, 32'h1234_5678, 1'b1, f);
    capture(got, ok);
    check(got == cmd_frame(6'd13, 32'h1234_5678), "R2 frame cmd13", got,
          cmd_frame(6'd13, 32'h1234_5678));
    r = short_rsp(6'd13, 32'h0000_0B00) ^ 48'h4;  // flip one CRC bit
    for (int k = 0; k < 5; k++) tick(1'b1);       // late start bit
    send_bits({88'b0, r}, 48);
    check(rsp_err == exp_err, req, rsp_err, exp_err);
    check(rsp_w3 == 32'h0000_0B00 && !busy, req, rsp_w3, 32'h0000_0B00);
  endtask

  task automatic t_short_endbit_nocrc;
    logic [47:0] got; bit ok;
    issue(6'd7, 32'h5, 1'b1, 2'd1);
    capture(got, ok);
    send_bits({88'b0, short_rsp(6'd7, 32'h77) & ~48'h1}, 48);
    check(rsp_err, "R7 end bit still checked", rsp_err, 1);
  endtask

  task automatic t_long(input bit bad_end);
    logic [47:0] got; bit ok; logic [135:0] r; logic [126:0] p;
    p = {32'hDEAD_BEEF, 32'h0123_4567, 32'h89AB_CDEF, 31'h7654_3210};
    r = {2'b00, 6'b111111, p, ~bad_end};
    issue(6'd2, 32'h0, 1'b1, 2'd2);
    capture(got, ok);
    send_bits(r, 136);
    check(rsp_err == bad_end, "R8 long end bit", rsp_err, bad_end);
    if (!bad_end) begin
      check({rsp_w3, rsp_w2, rsp_w1} == {32'hDEAD_BEEF, 32'h0123_4567, 32'h89AB_CDEF},
            "R8 long words 3..1", {rsp_w3, rsp_w2, rsp_w1},
            {32'hDEAD_BEEF, 32'h0123_4567, 32'h89AB_CDEF});
      check(rsp_w0 == {1'b0, 31'h7654_3210}, "R8 long word0 shifted", rsp_w0,
            {1'b0, 31'h7654_3210});
    end
  endtask

  task automatic t_timeout;
    logic [47:0] got; bit ok;
    issue(6'd8, 32'h1AA, 1'b1, 2'd0);
    capture(got, ok);
    for (int k = 0; k < 63; k++) tick(1'b1);
    check(busy && !no_rsp_err, "R5 still waiting at 63", {busy, no_rsp_err}, 2'b10);
    tick(1'b1);
    check(!busy && no_rsp_err && !rsp_err, "R5 timeout at 64",
          {busy, no_rsp_err, rsp_err}, 3'b010);
  endtask

  task automatic t_backpressure;
    logic [47:0] got; bit ok;
    issue(6'd24, 32'hA5A5_0F0F, 1'b0, 2'd0);
    got = '0;
    for (int k = 0; k < 48; k++) begin
      if (k == 2) begin cmd_valid = 1'b1; cmd_idx = 6'd55; cmd_arg = 32'hFFFF_FFFF; end
      if (k == 40) cmd_valid = 1'b0;
      if (k == 10) check(!cmd_ready, "R1 not ready in flight", cmd_ready, 0);
      // R10: no strobe, outputs must hold
      if (k == 20) begin
        logic o1, e1;
        o1 = cmd_out; e1 = cmd_oe;
        repeat (4) @(negedge clk);
        check(cmd_out == o1 && cmd_oe == e1, "R10 hold without strobe",
              {cmd_out, cmd_oe}, {o1, e1});
      end
      tick(1'b1);
      got = {got[46:0], cmd_out};
    end
    tick(1'b1);
    check(got == cmd_frame(6'd24, 32'hA5A5_0F0F), "R1 frame unchanged by held request",
          got, cmd_frame(6'd24, 32'hA5A5_0F0F));
    check(!busy, "R4 done", busy, 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_no_rsp_cmd0();
    t_short_ok();
    t_short_badcrc(2'd0, 1'b1, "R6 crc error flagged");
    t_short_badcrc(2'd1, 1'b0, "R7 crc ignored");
    t_short_endbit_nocrc();
    t_long(1'b0);
    t_long(1'b1);
    t_timeout();
    t_backpressure();
    t_short_ok();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule